// File: doc/BRIEF.md
# Dual-Channel DAC Register Bank with Command Decode

This block sits between a serial-interface deframer and a two-channel control DAC. Each transaction is one 8-bit command byte and one 16-bit data word. The block decodes that pair into a write to one of three register kinds for each channel:

- a setpoint register,
- a K-parameter register,
- a direct DAC input register.

Each channel has a double-buffered DAC: an input register feeds an output register, and only the output register drives the converter.

A setpoint write sends a one-cycle request to an external arithmetic engine. The request carries the channel number and an operand. The operand is either the new setpoint or the stored K-parameter, chosen by the channel's 3-bit K-source field. The computed code returns with a valid strobe. It is written into the input register one cycle later. If the channel's load-mode bit is set, it is also written into the output register.

A direct DAC-input write skips the calculation entirely. A per-channel load strobe copies the input register to the output register.

Top module: `dac_regbank`

## Requirements
- R1: With `cmd_valid` high, command byte 0x40 loads channel 0's setpoint and 0x42 loads channel 1's. Only bits 11:0 of `cmd_data` are stored and bits 15:12 are ignored. The new value appears on `setpoint_q` (channel 0 in bits 11:0, channel 1 in bits 23:12) after the accepting clock edge.
- R2: Command bytes 0x44 and 0x46 load the K-parameter register of channel 0 and channel 1 respectively, with bits 11:0 of the data. The value appears on `kparam_q`, using the same channel layout as R1.
- R3: Command bytes 0x48 and 0x4C write bits 11:0 of the data straight into the DAC input register of channel 0 and channel 1 respectively. The value appears on `dac_in_q` after that edge.
- R4: A setpoint write produces a single-cycle `calc_req` after the accepting edge, with `calc_chan` giving the channel. When the K-parameter is not selected, `calc_operand` equals the written 12-bit setpoint.
- R5: When the channel's K-source field (`ksrc` bits 3c+2:3c for channel c), sampled with the setpoint command, is 3'b010, 3'b101, 3'b110 or 3'b111, `calc_operand` is that channel's stored K-parameter instead of the setpoint.
- R6: A result given with `res_valid` at edge e is written into the input register of channel `res_chan` at edge e+1.
- R7: A result applied at edge e+1 reaches the output register at that same edge only if `load_mode` bit c is high, with the value sampled at edge e+1. Otherwise the output register is unaffected by the result.
- R8: `load_strobe` bit c copies the channel's input register into its output register at that edge, using the input register's value from before the edge.
- R9: If a direct input write and an applied result target the same channel at the same edge, the direct write wins. That result is then discarded for both registers of that channel.
- R10: If an applied result writes the output register through load mode at the same edge as a load strobe on that channel, the output register takes the result.
- R11: With `cmd_valid` high, any command byte other than the six listed changes no register. It pulses `illegal_cmd` high for exactly the cycle after the accepting edge.
- R12: Synchronous reset clears all setpoint, K-parameter, input and output registers to zero, and drives `calc_req` and `illegal_cmd` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte and data word are valid this cycle |
| cmd_byte | input | 8 | Command byte |
| cmd_data | input | 16 | Data word; bits 11:0 are used |
| load_mode | input | 2 | Per channel: calculated code also loads the output register |
| ksrc | input | 6 | Per channel 3-bit K-source field |
| load_strobe | input | 2 | Per channel: copy input register to output register |
| calc_req | output | 1 | One-cycle calculation request |
| calc_chan | output | 1 | Channel of the request |
| calc_operand | output | 12 | Operand of the request |
| res_valid | input | 1 | Calculation result valid |
| res_chan | input | 1 | Channel of the result |
| res_code | input | 12 | Calculated DAC code |
| setpoint_q | output | 24 | Setpoint registers, channel 0 in the low 12 bits |
| kparam_q | output | 24 | K-parameter registers |
| dac_in_q | output | 24 | DAC input registers |
| dac_out_q | output | 24 | DAC output registers |
| illegal_cmd | output | 1 | One-cycle unrecognised-command flag |

## Verification
The assertions assume that the deframer presents at most one command per cycle, and that `rst` is held for at least one clock edge before any check is expected to hold. They also assume that `res_chan` is a valid channel number whenever `res_valid` is high. The stimulus drives every input only at the falling edge. It draws command bytes half from the six legal codes and half at random, and it raises `res_valid` independently of the commands. The stimulus therefore keeps within these assumptions while still making results collide with direct writes and load strobes.

// File: rtl/dacrb_pkg.sv
package dacrb_pkg;
    localparam int NCH = 2;
    localparam int CW  = 12;
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int KSW = 3;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_SETPT,
        OP_KPAR,
        OP_DIRECT
    } op_e;

    typedef struct packed {
        logic           valid;
        logic           illegal;
        op_e            op;
        logic [CHW-1:0] ch;
        logic [CW-1:0]  val;
    } cmd_t;

    typedef struct packed {
        logic           valid;
        logic [CHW-1:0] ch;
        logic [CW-1:0]  code;
    } res_t;

    function automatic logic [7:0] setpt_byte(input int c);
        return 8'(8'h40 + 2 * c);
    endfunction

    function automatic logic [7:0] kpar_byte(input int c);
        return 8'(8'h44 + 2 * c);
    endfunction

    function automatic logic [7:0] direct_byte(input int c);
        return 8'(8'h48 + 4 * c);
    endfunction

    function automatic logic k_selected(input logic [KSW-1:0] src);
        return (src == 3'b010) || (src[2] && (src != 3'b100));
    endfunction
endpackage

// File: rtl/dacrb_decode.sv
module dacrb_decode
    import dacrb_pkg::*;
(
    input  logic        cmd_valid,
    input  logic [7:0]  cmd_byte,
    input  logic [15:0] cmd_data,
    output cmd_t        cmd
);
    always_comb begin
        cmd         = '0;
        cmd.valid   = cmd_valid;
        cmd.op      = OP_NONE;
        cmd.val     = cmd_data[CW-1:0];
        for (int c = 0; c < NCH; c++) begin
            if (cmd_byte == setpt_byte(c)) begin
                cmd.op = OP_SETPT;
                cmd.ch = CHW'(c);
            end else if (cmd_byte == kpar_byte(c)) begin
                cmd.op = OP_KPAR;
                cmd.ch = CHW'(c);
            end else if (cmd_byte == direct_byte(c)) begin
                cmd.op = OP_DIRECT;
                cmd.ch = CHW'(c);
            end
        end
        cmd.illegal = cmd_valid && (cmd.op == OP_NONE);
    end
endmodule

// File: rtl/dacrb_calc_port.sv
module dacrb_calc_port
    import dacrb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  cmd_t                cmd,
    input  logic [NCH*CW-1:0]   kpar_flat,
    input  logic [NCH*KSW-1:0]  ksrc,
    input  logic                res_valid,
    input  logic [CHW-1:0]      res_chan,
    input  logic [CW-1:0]       res_code,
    output logic                calc_req,
    output logic [CHW-1:0]      calc_chan,
    output logic [CW-1:0]       calc_operand,
    output res_t                res_q
);
    logic [CW-1:0]  kval;
    logic [KSW-1:0] src;

    always_comb begin
        kval = '0;
        src  = '0;
        for (int c = 0; c < NCH; c++) begin
            if (cmd.ch == CHW'(c)) begin
                kval = kpar_flat[c*CW +: CW];
                src  = ksrc[c*KSW +: KSW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            calc_req     <= 1'b0;
            calc_chan    <= '0;
            calc_operand <= '0;
            res_q        <= '0;
        end else begin
            calc_req <= cmd.valid && (cmd.op == OP_SETPT);
            if (cmd.valid && (cmd.op == OP_SETPT)) begin
                calc_chan    <= cmd.ch;
                calc_operand <= k_selected(src) ? kval : cmd.val;
            end
            res_q.valid <= res_valid;
            res_q.ch    <= res_chan;
            res_q.code  <= res_code;
        end
    end

    // R4
    req_single_chk: assert property (@(posedge clk) disable iff (rst)
        calc_req |=> !calc_req || $past(cmd.valid));

    // R6
    res_stage_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> res_q.valid && (res_q.code == $past(res_code)));
endmodule

// File: rtl/dacrb_chan.sv
module dacrb_chan
    import dacrb_pkg::*;
#(
    parameter int CH = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  cmd_t          cmd,
    input  res_t          res_q,
    input  logic          load_mode,
    input  logic          load_strobe,
    output logic [CW-1:0] setpt,
    output logic [CW-1:0] kpar,
    output logic [CW-1:0] din,
    output logic [CW-1:0] dout
);
    logic mine, wr_sp, wr_k, wr_dir, apply, apply_out;

    assign mine      = cmd.valid && (cmd.ch == CHW'(CH));
    assign wr_sp     = mine && (cmd.op == OP_SETPT);
    assign wr_k      = mine && (cmd.op == OP_KPAR);
    assign wr_dir    = mine && (cmd.op == OP_DIRECT);
    assign apply     = res_q.valid && (res_q.ch == CHW'(CH)) && !wr_dir;
    assign apply_out = apply && load_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            setpt <= '0;
            kpar  <= '0;
            din   <= '0;
            dout  <= '0;
        end else begin
            if (wr_sp) setpt <= cmd.val;
            if (wr_k)  kpar  <= cmd.val;
            if (wr_dir)     din <= cmd.val;
            else if (apply) din <= res_q.code;
            if (apply_out)        dout <= res_q.code;
            else if (load_strobe) dout <= din;
        end
    end

    // R3
    direct_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_dir |=> din == $past(cmd.val));

    // R8
    strobe_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (load_strobe && !apply_out) |=> dout == $past(din));

    // R11
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd.illegal && !res_q.valid && !load_strobe) |=>
            $stable(setpt) && $stable(kpar) && $stable(din) && $stable(dout));

    // R12
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (setpt == '0) && (din == '0) && (dout == '0));
endmodule

// File: rtl/dac_regbank.sv
module dac_regbank
    import dacrb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [7:0]          cmd_byte,
    input  logic [15:0]         cmd_data,
    input  logic [NCH-1:0]      load_mode,
    input  logic [NCH*KSW-1:0]  ksrc,
    input  logic [NCH-1:0]      load_strobe,
    output logic                calc_req,
    output logic [CHW-1:0]      calc_chan,
    output logic [CW-1:0]       calc_operand,
    input  logic                res_valid,
    input  logic [CHW-1:0]      res_chan,
    input  logic [CW-1:0]       res_code,
    output logic [NCH*CW-1:0]   setpoint_q,
    output logic [NCH*CW-1:0]   kparam_q,
    output logic [NCH*CW-1:0]   dac_in_q,
    output logic [NCH*CW-1:0]   dac_out_q,
    output logic                illegal_cmd
);
    cmd_t cmd;
    res_t res_q;

    dacrb_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .cmd_data  (cmd_data),
        .cmd       (cmd)
    );

    dacrb_calc_port u_calc (
        .clk          (clk),
        .rst          (rst),
        .cmd          (cmd),
        .kpar_flat    (kparam_q),
        .ksrc         (ksrc),
        .res_valid    (res_valid),
        .res_chan     (res_chan),
        .res_code     (res_code),
        .calc_req     (calc_req),
        .calc_chan    (calc_chan),
        .calc_operand (calc_operand),
        .res_q        (res_q)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [CW-1:0] sp_w, k_w, in_w, out_w;

        dacrb_chan #(.CH(c)) u_ch (
            .clk         (clk),
            .rst         (rst),
            .cmd         (cmd),
            .res_q       (res_q),
            .load_mode   (load_mode[c]),
            .load_strobe (load_strobe[c]),
            .setpt       (sp_w),
            .kpar        (k_w),
            .din         (in_w),
            .dout        (out_w)
        );

        assign setpoint_q[c*CW +: CW] = sp_w;
        assign kparam_q[c*CW +: CW]   = k_w;
        assign dac_in_q[c*CW +: CW]   = in_w;
        assign dac_out_q[c*CW +: CW]  = out_w;
    end

    always_ff @(posedge clk) begin
        if (rst) illegal_cmd <= 1'b0;
        else     illegal_cmd <= cmd.illegal;
    end

    // R11
    illegal_src_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_cmd |-> $past(cmd_valid) && !calc_req);

    // R4
    req_src_chk: assert property (@(posedge clk) disable iff (rst)
        calc_req |-> $past(cmd_valid) && !illegal_cmd);
endmodule

// File: tb/dac_regbank_tb_top.sv
`timescale 1ns/1ps
module dac_regbank_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_byte = '0;
    logic [15:0] cmd_data = '0;
    logic [1:0]  load_mode = '0;
    logic [5:0]  ksrc = '0;
    logic [1:0]  load_strobe = '0;
    logic        res_valid = 1'b0;
    logic        res_chan = 1'b0;
    logic [11:0] res_code = '0;
    logic        calc_req, calc_chan, illegal_cmd;
    logic [11:0] calc_operand;
    logic [23:0] setpoint_q, kparam_q, dac_in_q, dac_out_q;

    always #2.5 clk = ~clk;

    dac_regbank dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .cmd_data(cmd_data), .load_mode(load_mode), .ksrc(ksrc),
        .load_strobe(load_strobe), .calc_req(calc_req), .calc_chan(calc_chan),
        .calc_operand(calc_operand), .res_valid(res_valid), .res_chan(res_chan),
        .res_code(res_code), .setpoint_q(setpoint_q), .kparam_q(kparam_q),
        .dac_in_q(dac_in_q), .dac_out_q(dac_out_q), .illegal_cmd(illegal_cmd)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    logic [11:0] m_sp[2], m_k[2], m_in[2], m_out[2];
    logic        m_req, m_rch, m_ill;
    logic [11:0] m_rop;
    logic        pr_v, pr_ch;
    logic [11:0] pr_code;

    function automatic bit ksel(input logic [2:0] s);
        return s == 3'b010 || s == 3'b101 || s == 3'b110 || s == 3'b111;
    endfunction

    // kind: 0 none, 1 setpoint, 2 K, 3 direct
    function automatic int kind_of(input logic [7:0] b, output int ch);
        ch = 0;
        case (b)
            8'h40: begin ch = 0; return 1; end
            8'h42: begin ch = 1; return 1; end
            8'h44: begin ch = 0; return 2; end
            8'h46: begin ch = 1; return 2; end
            8'h48: begin ch = 0; return 3; end
            8'h4C: begin ch = 1; return 3; end
            default: return 0;
        endcase
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_sp[c] = '0; m_k[c] = '0; m_in[c] = '0; m_out[c] = '0;
        end
        m_req = 0; m_rch = 0; m_rop = '0; m_ill = 0;
        pr_v = 0; pr_ch = 0; pr_code = '0;
    endtask

    task automatic model_step();
        int ch;
        int k;
        logic [11:0] v;
        logic [11:0] nin[2], nout[2];
        k = kind_of(cmd_byte, ch);
        v = cmd_data[11:0];
        m_ill = cmd_valid && (k == 0);
        m_req = cmd_valid && (k == 1);
        if (m_req) begin
            m_rch = 1'(ch);
            m_rop = ksel(ksrc[ch*3 +: 3]) ? m_k[ch] : v;
        end
        for (int c = 0; c < 2; c++) begin
            bit dw, ap;
            dw = cmd_valid && (k == 3) && (ch == c);
            ap = pr_v && (pr_ch == 1'(c)) && !dw;
            nin[c]  = dw ? v : (ap ? pr_code : m_in[c]);
            nout[c] = (ap && load_mode[c]) ? pr_code :
                      (load_strobe[c] ? m_in[c] : m_out[c]);
        end
        for (int c = 0; c < 2; c++) begin
            m_in[c] = nin[c]; m_out[c] = nout[c];
        end
        if (cmd_valid && k == 1) m_sp[ch] = v;
        if (cmd_valid && k == 2) m_k[ch] = v;
        pr_v = res_valid; pr_ch = res_chan; pr_code = res_code;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R1 setpoint", 32'(setpoint_q), 32'({m_sp[1], m_sp[0]}));
        chk("R2 kparam", 32'(kparam_q), 32'({m_k[1], m_k[0]}));
        chk("R3/R6/R9 dac_in", 32'(dac_in_q), 32'({m_in[1], m_in[0]}));
        chk("R7/R8/R10 dac_out", 32'(dac_out_q), 32'({m_out[1], m_out[0]}));
        chk("R4 calc_req", 32'(calc_req), 32'(m_req));
        if (m_req) chk("R4/R5 calc chan/operand", 32'({calc_chan, calc_operand}), 32'({m_rch, m_rop}));
        chk("R11 illegal", 32'(illegal_cmd), 32'(m_ill));
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        cmd_valid = 0; res_valid = 0; load_strobe = '0;
    endtask

    task automatic cmd(input logic [7:0] b, input logic [15:0] d);
        cmd_valid = 1; cmd_byte = b; cmd_data = d;
    endtask

    task automatic res(input logic ch, input logic [11:0] code);
        res_valid = 1; res_chan = ch; res_code = code;
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h1234_5678));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12 reset state
        chk("R12 reset setpoint", 32'(setpoint_q), 0);
        chk("R12 reset dac_out", 32'(dac_out_q), 0);
        chk("R12 reset flags", 32'({calc_req, illegal_cmd}), 0);
        rst = 0;

        // R1: upper nibble ignored
        cmd(8'h40, 16'hF123); cycle();
        cmd(8'h42, 16'hA456); cycle();
        // R2
        cmd(8'h44, 16'h0ABC); cycle();
        cmd(8'h46, 16'h5DEF); cycle();
        // R5: ksrc 010 on ch0 selects K; 100 on ch1 does not
        ksrc = 6'b100_010;
        cmd(8'h40, 16'h0777); cycle();
        cmd(8'h42, 16'h0888); cycle();
        ksrc = 6'b111_101;
        cmd(8'h42, 16'h0999); cycle();
        ksrc = '0;
        // R3
        cmd(8'h48, 16'hF111); cycle();
        cmd(8'h4C, 16'h0222); cycle();
        // R6/R7: result into ch1 with load mode, ch0 without
        load_mode = 2'b10;
        res(1'b1, 12'h3A3); cycle(); cycle();
        res(1'b0, 12'h4B4); cycle(); cycle();
        // R8: strobe copy
        load_strobe = 2'b01; cycle();
        // R9: direct write collides with result apply on ch0
        res(1'b0, 12'h5C5); cycle();
        cmd(8'h48, 16'h0666); cycle(); cycle();
        // R10: load-mode result and strobe on same edge, ch0
        load_mode = 2'b01;
        res(1'b0, 12'h7D7); cycle();
        load_strobe = 2'b01; cycle(); cycle();
        // R11: illegal bytes
        cmd(8'h41, 16'hFFFF); cycle();
        cmd(8'h4A, 16'h1234); cycle(); cycle();

        // Constrained random mix
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 2) != 0) begin
                logic [7:0] b;
                case ($urandom_range(0, 11))
                    0: b = 8'h40; 1: b = 8'h42; 2: b = 8'h44;
                    3: b = 8'h46; 4: b = 8'h48; 5: b = 8'h4C;
                    default: b = 8'($urandom);
                endcase
                cmd(b, 16'($urandom));
            end
            if ($urandom_range(0, 2) == 0) res(1'($urandom), 12'($urandom));
            load_strobe = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b00;
            load_mode = 2'($urandom);
            ksrc = 6'($urandom);
            cycle();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule